// File: doc/BRIEF.md
# Bitmask Immediate Encoder

This block decides whether a 64-bit constant can be written as a short element that repeats across the register. That element must hold one contiguous run of ones, and the run may be rotated within the element. When the constant qualifies, the block produces the compact 13-bit code that describes it. The code has three fields: a flag set only for a full 64-bit element, a 6-bit rotation, and a 6-bit field that gives both the element size and the run length.

A size select chooses between a 64-bit register and a 32-bit register. In 32-bit mode only the low word is meaningful. The search first finds the smallest repeating element by halving, with elements from 2 up to the register width. It then looks for a single rising edge, taken circularly, inside that element. This one test covers both a plain run and a run that wraps past the element's top bit. Results are captured in an output register, one result per input beat.

Top module: `bmi_encoder`

## Requirements
- R1: An input of all zeros or all ones is reported as not encodable.
- R2: With the 32-bit select high, the input is not encodable if any of bits 63:32 is set or if bits 31:0 are all ones.
- R3: The element size is the smallest power of two, at least 2 and at most the register width, whose repetition reproduces the input.
- R4: The input is encodable only when its element holds exactly one run of ones, counted circularly. A run that crosses the element's top bit qualifies, and two or more separate runs do not.
- R5: Code bits 11:6 carry the rotation: the element equals a right-aligned run of ones rotated right by that count, modulo the element size.
- R6: Code bit 12 is set only for a 64-bit element. Code bits 5:0 are the run length minus one, ORed with a prefix of ones from bit 5 down to bit log2(size)+1, followed by a zero at bit log2(size). For example, a 2-bit element gives prefix 111100 and a 32- or 64-bit element gives 000000.
- R7: When the result is not encodable, the code output is zero.
- R8: out_vld equals in_vld from the previous clock edge. out_ok is only ever high together with out_vld.
- R9: While reset is asserted, out_vld, out_ok and out_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input beat present |
| in_val | input | 64 | Candidate constant |
| in_sz32 | input | 1 | High selects a 32-bit register, low a 64-bit register |
| out_vld | output | 1 | Result present, one cycle after in_vld |
| out_ok | output | 1 | Constant is encodable |
| out_code | output | 13 | Flag (12), rotation (11:6), size and length (5:0); zero if not encodable |

## Verification
The bench builds the block with its default parameters: a 64-bit value width and the registered output. This configuration is small enough to sweep every encodable constant in both size modes. That means every element size from 2 to 64, every run length and every rotation, which covers the wrap-around runs and the smallest-period cases completely. Random and single-bit-corrupted constants then exercise rejection. Each result is compared with a brute-force period-and-rotation search and with a separate decoder that rebuilds the constant from the code.

// File: rtl/bmi_pkg.sv
`timescale 1ns/1ps
package bmi_pkg;
   localparam int unsigned BMI_VAL_W = 64;
   localparam int unsigned BMI_LVL_W = 3;
   typedef logic [BMI_LVL_W-1:0] lvl_t;
endpackage

// File: rtl/bmi_period.sv
`timescale 1ns/1ps
module bmi_period import bmi_pkg::*; #(
   parameter int unsigned VAL_W = BMI_VAL_W,
   localparam int unsigned FLD_W = $clog2(VAL_W)
) (
   input  logic [VAL_W-1:0] val,
   input  logic             sz32,
   output lvl_t             lvl
);
   logic [FLD_W-1:1] halves_eq;

   for (genvar k = 1; k < FLD_W; k++) begin : g_cmp
      localparam int unsigned H = 2 ** k;
      assign halves_eq[k] = (val[H-1:0] == val[2*H-1:H]);
   end

   always_comb begin
      int unsigned top;
      logic        stop;
      top  = sz32 ? FLD_W - 1 : FLD_W;
      lvl  = lvl_t'(top);
      stop = 1'b0;
      for (int k = FLD_W - 1; k >= 1; k--) begin
         if (k < top && !stop) begin
            if (halves_eq[k]) lvl = lvl_t'(k);
            else              stop = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bmi_run.sv
`timescale 1ns/1ps
module bmi_run import bmi_pkg::*; #(
   parameter int unsigned VAL_W = BMI_VAL_W,
   localparam int unsigned FLD_W = $clog2(VAL_W),
   localparam int unsigned NSLOT = 2 ** BMI_LVL_W
) (
   input  logic [VAL_W-1:0] val,
   input  lvl_t             lvl,
   output logic             single,
   output logic [FLD_W-1:0] rot,
   output logic [FLD_W-1:0] ones
);
   logic             ok_a   [0:NSLOT-1];
   logic [FLD_W-1:0] rot_a  [0:NSLOT-1];
   logic [FLD_W-1:0] ones_a [0:NSLOT-1];

   for (genvar l = 0; l < NSLOT; l++) begin : g_lvl
      if (l >= 1 && l <= FLD_W) begin : g_on
         localparam int unsigned S = 2 ** l;
         logic [S-1:0]     elem, rise;
         logic [FLD_W-1:0] pos;
         assign elem = val[S-1:0];
         assign rise = elem & ~{elem[S-2:0], elem[S-1]};
         always_comb begin
            pos = '0;
            for (int i = 0; i < S; i++)
               if (rise[i]) pos = FLD_W'(i);
         end
         assign ok_a[l]   = ($countones(rise) == 1);
         assign rot_a[l]  = pos;
         assign ones_a[l] = FLD_W'($countones(elem));
      end else begin : g_off
         assign ok_a[l]   = 1'b0;
         assign rot_a[l]  = '0;
         assign ones_a[l] = '0;
      end
   end

   assign single = ok_a[lvl];
   assign rot    = rot_a[lvl];
   assign ones   = ones_a[lvl];
endmodule

// File: rtl/bmi_pack.sv
`timescale 1ns/1ps
module bmi_pack import bmi_pkg::*; #(
   parameter int unsigned VAL_W = BMI_VAL_W,
   localparam int unsigned FLD_W = $clog2(VAL_W),
   localparam int unsigned CODE_W = 2 * FLD_W + 1
) (
   input  lvl_t              lvl,
   input  logic [FLD_W-1:0]  rot,
   input  logic [FLD_W-1:0]  ones,
   output logic [CODE_W-1:0] code
);
   logic [FLD_W-1:0] szm1, immr, imms, len_m1;

   assign szm1   = FLD_W'((1 << lvl) - 1);
   assign immr   = (~rot + FLD_W'(1)) & szm1;
   assign len_m1 = ones - FLD_W'(1);
   assign imms   = {~szm1[FLD_W-2:0], 1'b0} | len_m1;
   assign code   = {szm1[FLD_W-1], immr, imms};
endmodule

// File: rtl/bmi_encoder.sv
`timescale 1ns/1ps
module bmi_encoder import bmi_pkg::*; #(
   parameter int unsigned VAL_W = BMI_VAL_W,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned FLD_W = $clog2(VAL_W),
   localparam int unsigned CODE_W = 2 * FLD_W + 1,
   localparam int unsigned HALF = VAL_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [VAL_W-1:0]  in_val,
   input  logic              in_sz32,
   output logic              out_vld,
   output logic              out_ok,
   output logic [CODE_W-1:0] out_code
);
   if (VAL_W != 64) begin : g_bad_width
      $error("bmi_encoder: VAL_W must be 64");
   end

   lvl_t              lvl;
   logic              single, reject, enc;
   logic [FLD_W-1:0]  rot, ones;
   logic [CODE_W-1:0] raw_code, code_c;

   assign reject = (in_val == '0) || (in_val == '1) ||
                   (in_sz32 && ((in_val[VAL_W-1:HALF] != '0) ||
                                (in_val[HALF-1:0] == '1)));

   bmi_period #(.VAL_W(VAL_W)) u_period (
      .val (in_val), .sz32(in_sz32), .lvl(lvl));

   bmi_run #(.VAL_W(VAL_W)) u_run (
      .val(in_val), .lvl(lvl), .single(single), .rot(rot), .ones(ones));

   bmi_pack #(.VAL_W(VAL_W)) u_pack (
      .lvl(lvl), .rot(rot), .ones(ones), .code(raw_code));

   assign enc    = !reject && single;
   assign code_c = enc ? raw_code : '0;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld  <= 1'b0;
            out_ok   <= 1'b0;
            out_code <= '0;
         end else begin
            out_vld  <= in_vld;
            out_ok   <= in_vld && enc;
            out_code <= in_vld ? code_c : '0;
         end
      end
   end else begin : g_comb
      assign out_vld  = in_vld;
      assign out_ok   = in_vld && enc;
      assign out_code = in_vld ? code_c : '0;
   end
endmodule

// File: rtl/bmi_encoder_chk.sv
`timescale 1ns/1ps
module bmi_encoder_chk #(
   parameter int unsigned VAL_W = 64,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned CODE_W = 2 * $clog2(VAL_W) + 1,
   localparam int unsigned HALF = VAL_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [VAL_W-1:0]  in_val,
   input logic              in_sz32,
   input logic              out_vld,
   input logic              out_ok,
   input logic [CODE_W-1:0] out_code
);
   // R7
   zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ok |-> out_code == '0);

   // R8
   ok_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ok |-> out_vld);

   if (OUT_REG) begin : g_seq
      // R8
      vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);

      // R8
      idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld);

      // R1
      trivial_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld && (in_val == '0 || in_val == '1) |=> !out_ok);

      // R2
      narrow_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld && in_sz32 &&
         (in_val[VAL_W-1:HALF] != '0 || in_val[HALF-1:0] == '1) |=> !out_ok);

      // R6
      narrow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld && in_sz32 |=> !out_code[CODE_W-1]);
   end
endmodule

bind bmi_encoder bmi_encoder_chk #(.VAL_W(VAL_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_bmi_encoder.sv
`timescale 1ns/1ps
module sim_bmi_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [63:0] in_val = '0;
   logic        in_sz32 = 1'b0;
   logic        out_vld, out_ok;
   logic [12:0] out_code;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   bmi_encoder u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_val(in_val),
      .in_sz32(in_sz32), .out_vld(out_vld), .out_ok(out_ok), .out_code(out_code));

   always #5 clk = ~clk;

   task automatic check(input bit cond, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] msk(input int s);
      return (s >= 64) ? '1 : ((64'd1 << s) - 64'd1);
   endfunction

   function automatic logic [63:0] rotr(input logic [63:0] e, input int r, input int s);
      if (r == 0) return e;
      return ((e >> r) | (e << (s - r))) & msk(s);
   endfunction

   function automatic logic [63:0] repl(input logic [63:0] e, input int s, input int w);
      logic [63:0] v = '0;
      for (int p = 0; p < w; p += s) v |= e << p;
      return v;
   endfunction

   // brute-force search: smallest period, then any rotation of a run
   function automatic bit ref_enc(input logic [63:0] v, input bit m32,
                                  output logic [12:0] code);
      int w = m32 ? 32 : 64;
      int s = w;
      logic [63:0] e;
      int k;
      code = '0;
      if (m32 && v[63:32] != 0) return 1'b0;
      for (int t = w; t >= 2; t /= 2)
         if (repl(v & msk(t), t, w) == v) s = t;
      e = v & msk(s);
      k = $countones(e);
      if (k == 0 || k == s) return 1'b0;
      for (int r = 0; r < s; r++)
         if (rotr(msk(k), r, s) == e) begin
            code = {(s == 64), 6'(r), 6'(63 & ~(2 * s - 1)) | 6'(k - 1)};
            return 1'b1;
         end
      return 1'b0;
   endfunction

   function automatic logic [63:0] decode(input logic [12:0] c, input bit m32);
      int w = m32 ? 32 : 64;
      int s = 0;
      int len, r;
      if (c[12]) s = 64;
      else
         for (int j = 0; j < 6; j++) if (!c[j]) s = 1 << j;
      if (s < 2) return '0;
      len = int'(c[5:0]) % s + 1;
      r   = int'(c[11:6]) % s;
      return repl(rotr(msk(len), r, s), s, w);
   endfunction

   task automatic apply(input logic [63:0] v, input bit m32, input string req);
      logic [12:0] ecode;
      bit eok;
      in_val  = v;
      in_sz32 = m32;
      in_vld  = 1'b1;
      @(negedge clk);
      eok = ref_enc(v, m32, ecode);
      check(out_vld == 1'b1, "R8", 64'(out_vld), 64'd1);
      check(out_ok == eok, req, 64'(out_ok), 64'(eok));
      if (eok) begin
         check(out_code == ecode, req, 64'(out_code), 64'(ecode));
         check(decode(out_code, m32) == v, "R5", decode(out_code, m32), v);
      end else begin
         check(out_code == '0, "R7", 64'(out_code), 64'd0);
      end
   endtask

   task automatic expect_code(input logic [63:0] v, input bit m32,
                              input logic [12:0] c, input string req);
      apply(v, m32, req);
      check(out_ok && out_code == c, req, 64'(out_code), 64'(c));
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_vld == 0 && out_ok == 0 && out_code == 0, "R9", 64'(out_code), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1
      apply(64'h0, 1'b0, "R1");
      check(!out_ok, "R1", 64'(out_ok), 64'd0);
      apply('1, 1'b0, "R1");
      check(!out_ok, "R1", 64'(out_ok), 64'd0);
      apply(64'h0, 1'b1, "R1");
      // R2
      apply(64'h0000_0000_FFFF_FFFF, 1'b1, "R2");
      check(!out_ok, "R2", 64'(out_ok), 64'd0);
      apply(64'h0000_0001_0000_0001, 1'b1, "R2");
      check(!out_ok, "R2", 64'(out_ok), 64'd0);
      // R6 full-width element, 32 ones, no rotation
      expect_code(64'h0000_0000_FFFF_FFFF, 1'b0, 13'h101F, "R6");
      // R3 two-bit element, R5 rotation of one
      expect_code(64'h5555_5555_5555_5555, 1'b0, 13'h003C, "R3");
      expect_code(64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 13'h007C, "R5");
      expect_code(64'h0000_0000_5555_5555, 1'b1, 13'h003C, "R3");
      // R4 wrapping run and two separate runs
      expect_code(64'h8000_0000_0000_0001, 1'b0, 13'h1041, "R4");
      apply(64'h0000_0000_0000_0005, 1'b0, "R4");
      check(!out_ok, "R4", 64'(out_ok), 64'd0);

      // R8 idle beat
      in_vld = 1'b0;
      @(negedge clk);
      check(!out_vld && !out_ok, "R8", 64'(out_vld), 64'd0);

      // R3 R4 R5 R6 exhaustive sweep of encodable constants, both modes
      for (int m = 0; m < 2; m++) begin
         int w = m ? 32 : 64;
         for (int s = 2; s <= w; s *= 2)
            for (int k = 1; k < s; k++)
               for (int r = 0; r < s; r++)
                  apply(repl(rotr(msk(k), r, s), s, w), m[0], "R3");
      end

      // R4 R2 random and corrupted constants
      for (int n = 0; n < 3000; n++) begin
         bit m = n[0];
         int s = 2 << ($urandom % (m ? 5 : 6));
         int k = 1 + int'($urandom % (s - 1));
         int r = int'($urandom % s);
         logic [63:0] v = repl(rotr(msk(k), r, s), s, m ? 32 : 64);
         v ^= 64'd1 << ($urandom % (m ? 32 : 64));
         apply(v, m, "R4");
         v = {$urandom, $urandom};
         if (m && n[1]) v[63:32] = '0;
         apply(v, m, "R2");
      end

      in_vld = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule